// File: doc/BRIEF.md
# Period Timer with Pulse and Square-Wave Output

The block is a programmable up-counting timer. An external one-cycle count strobe advances a counter. While the timer runs, the counter returns to zero on the clock after it equals the period value. Each such period match drives a status signal. In pulse mode the status goes high for a programmable number of strobe intervals (one or two). In square-wave mode the status toggles, so the output has a 50% duty cycle and a period of twice the programmed value.

Each rising edge of the status raises a one-cycle interrupt and an identical DMA sync event. An output pin carries either the optionally inverted status or a software data bit.

Software reaches the control, period and count values through a single-cycle register port. A write takes effect on the next clock edge. The read data is combinational from the address. The generation of the count strobe from any clock source happens outside the block.

Top module: `period_timer`

## Requirements
- R1: After reset, all three registers read 0 (control at address 0, period at address 1, count at address 2; other addresses read 0). The status, read back in control bit 11, is 0. The pin, the interrupt and the DMA event are 0.
- R2: A control write with both the run bit (bit 0) and the start bit (bit 1) set does two things. It zeroes the count on that clock, and counting proceeds with the following strobes. The start bit always reads 0. A start bit written with the run bit clear leaves the count unchanged.
- R3: While the run bit is set, each strobe adds 1 to the count. A count equal to the period returns to 0 on the next clock whether or not a strobe arrives, so one output period spans the period value in strobes.
- R4: While the run bit is clear, the count and the status are frozen. Setting the run bit again without the start bit resumes from the frozen count.
- R5: A count above the period keeps counting up through all ones, wraps to 0, and continues.
- R6: Pulse mode is selected by control bit 2 at 0. The status goes to 1 on the clock after a period match. It returns to 0 on the Nth strobe after the match, where N is 1 when width bit 3 is 0 and 2 when it is 1. The exception is that strobe bringing the count to the period, in which case the status stays 1. As a result the status stays high when period ≤ N, including period 0, held or running.
- R7: Square-wave mode is selected by control bit 2 at 1. The status inverts on the clock after each period match. With period 0 and count 0 it toggles on every clock while running and keeps its value while held.
- R8: A bus write to the count in the same cycle as an increment or a wrap wins: the count takes the written value.
- R9: The interrupt and the DMA event are identical one-cycle pulses, raised in the first cycle the status reads 1 after reading 0.
- R10: With pin-select bit 4 at 1 the pin carries the status XOR invert bit 5. With bit 4 at 0 it carries data bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_stb | input | 1 | One-cycle count strobe |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | ADDR_W | Register address (0 control, 1 period, 2 count) |
| reg_wdata | input | CNT_W | Register write data |
| reg_rdata | output | CNT_W | Register read data for reg_addr |
| tmr_out | output | 1 | Output pin value |
| irq | output | 1 | Interrupt pulse on status rise |
| dma_evt | output | 1 | DMA sync pulse on status rise |

## Verification
The behaviour of a wrong count shows at once on the count read-back, and one period later on the pin as a misplaced status edge. A wrong remaining-width value shows as a pulse one strobe too long or too short, or as a pulse that drops when the period is at or below the width. A wrong hold or priority decision shows on the next clock, through the count read or the status bit. The bench therefore compares the pin, both pulse outputs and the read data against its model on every clock, so a divergence is reported in the cycle it first reaches a port.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int A_CTL = 0;
  localparam int A_PRD = 1;
  localparam int A_CNT = 2;

  localparam int B_RUN   = 0;
  localparam int B_START = 1;
  localparam int B_SQ    = 2;
  localparam int B_WIDE  = 3;
  localparam int B_PINT  = 4;
  localparam int B_PINV  = 5;
  localparam int B_PLVL  = 6;
  localparam int B_STAT  = 11;

  typedef struct packed {
    logic pin_level;
    logic pin_inv;
    logic pin_timer;
    logic wide;
    logic sq_mode;
    logic run;
  } ctl_t;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output ctl_t              ctl_o,
  output logic [CNT_W-1:0]  prd_o,
  output logic              start_o,
  output logic              cnt_wr_o
);
  ctl_t             ctl_q, ctl_n;
  logic [CNT_W-1:0] prd_q, prd_n;
  logic             ctl_sel, prd_sel;

  assign ctl_sel  = reg_we && (reg_addr == ADDR_W'(A_CTL));
  assign prd_sel  = reg_we && (reg_addr == ADDR_W'(A_PRD));
  assign cnt_wr_o = reg_we && (reg_addr == ADDR_W'(A_CNT));
  assign start_o  = ctl_sel && reg_wdata[B_RUN] && reg_wdata[B_START];

  always_comb begin
    ctl_n = ctl_q;
    prd_n = prd_q;
    if (ctl_sel) begin
      ctl_n.run       = reg_wdata[B_RUN];
      ctl_n.sq_mode   = reg_wdata[B_SQ];
      ctl_n.wide      = reg_wdata[B_WIDE];
      ctl_n.pin_timer = reg_wdata[B_PINT];
      ctl_n.pin_inv   = reg_wdata[B_PINV];
      ctl_n.pin_level = reg_wdata[B_PLVL];
    end
    if (prd_sel) prd_n = reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      prd_q <= '0;
    end else begin
      ctl_q <= ctl_n;
      prd_q <= prd_n;
    end
  end

  assign ctl_o = ctl_q;
  assign prd_o = prd_q;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             stb_i,
  input  logic             start_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] prd_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_o,
  output logic             will_match_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_n, cnt_inc;
  logic             adv;

  assign cnt_inc      = cnt_q + ONE;
  assign adv          = run_i && stb_i;
  assign match_o      = run_i && (cnt_q == prd_i);
  assign will_match_o = adv && (cnt_inc == prd_i);

  always_comb begin
    cnt_n = cnt_q;
    if (wr_i)         cnt_n = wdata_i;
    else if (start_i) cnt_n = '0;
    else if (match_o) cnt_n = '0;
    else if (adv)     cnt_n = cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr_status.sv
module tmr_status #(
  parameter int WID_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic stb_i,
  input  logic sq_i,
  input  logic wide_i,
  input  logic match_i,
  input  logic will_match_i,
  output logic status_o,
  output logic rise_o
);
  localparam logic [WID_W-1:0] W_ONE = WID_W'(1);
  localparam logic [WID_W-1:0] W_TWO = WID_W'(2);

  logic             st_q, st_n, st_d_q;
  logic [WID_W-1:0] rem_q, rem_n;

  always_comb begin
    st_n  = st_q;
    rem_n = rem_q;
    if (match_i) begin
      st_n  = sq_i ? ~st_q : 1'b1;
      rem_n = wide_i ? W_TWO : W_ONE;
    end else if (!sq_i && run_i && stb_i && (rem_q != '0)) begin
      rem_n = rem_q - W_ONE;
      if ((rem_q == W_ONE) && !will_match_i) st_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= 1'b0;
      st_d_q <= 1'b0;
      rem_q  <= '0;
    end else begin
      st_q   <= st_n;
      st_d_q <= st_q;
      rem_q  <= rem_n;
    end
  end

  assign status_o = st_q;
  assign rise_o   = st_q && !st_d_q;
endmodule

// File: rtl/period_timer.sv
module period_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_stb,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              tmr_out,
  output logic              irq,
  output logic              dma_evt
);
  ctl_t             ctl_s;
  logic [CNT_W-1:0] prd_s, cnt_s;
  logic             start_s, cnt_wr_s, match_s, will_s, status_s, rise_s;

  tmr_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ctl_o(ctl_s), .prd_o(prd_s),
    .start_o(start_s), .cnt_wr_o(cnt_wr_s)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run_i(ctl_s.run), .stb_i(cnt_stb),
    .start_i(start_s), .wr_i(cnt_wr_s), .wdata_i(reg_wdata),
    .prd_i(prd_s), .cnt_o(cnt_s), .match_o(match_s), .will_match_o(will_s)
  );

  tmr_status #(.WID_W(2)) u_stat (
    .clk(clk), .rst_n(rst_n), .run_i(ctl_s.run), .stb_i(cnt_stb),
    .sq_i(ctl_s.sq_mode), .wide_i(ctl_s.wide), .match_i(match_s),
    .will_match_i(will_s), .status_o(status_s), .rise_o(rise_s)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(A_CTL): begin
        reg_rdata[B_RUN]  = ctl_s.run;
        reg_rdata[B_SQ]   = ctl_s.sq_mode;
        reg_rdata[B_WIDE] = ctl_s.wide;
        reg_rdata[B_PINT] = ctl_s.pin_timer;
        reg_rdata[B_PINV] = ctl_s.pin_inv;
        reg_rdata[B_PLVL] = ctl_s.pin_level;
        reg_rdata[B_STAT] = status_s;
      end
      ADDR_W'(A_PRD): reg_rdata = prd_s;
      ADDR_W'(A_CNT): reg_rdata = cnt_s;
      default:        reg_rdata = '0;
    endcase
  end

  assign tmr_out = ctl_s.pin_timer ? (status_s ^ ctl_s.pin_inv) : ctl_s.pin_level;
  assign irq     = rise_s;
  assign dma_evt = rise_s;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [CNT_W-1:0]  reg_wdata,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  prd,
  input logic              run,
  input logic              sq,
  input logic              status,
  input logic              irq,
  input logic              dma_evt
);
  logic cnt_wr, ctl_start;
  assign cnt_wr    = reg_we && (reg_addr == ADDR_W'(A_CNT));
  assign ctl_start = reg_we && (reg_addr == ADDR_W'(A_CTL)) && reg_wdata[B_RUN] && reg_wdata[B_START];

  a_r2_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_start |=> (cnt == '0));

  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (cnt == prd) && !cnt_wr) |=> (cnt == '0));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !reg_we) |=> ($stable(cnt) && $stable(status)));

  a_r6_pulse_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !sq && (cnt == prd)) |=> status);

  a_r7_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sq && (cnt == prd)) |=> (status != $past(status)));

  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt == $past(reg_wdata)));

  a_r9_irq_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status && dma_evt));

  a_r9_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
endmodule

bind period_timer tmr_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .cnt(cnt_s), .prd(prd_s), .run(ctl_s.run),
  .sq(ctl_s.sq_mode), .status(status_s), .irq(irq), .dma_evt(dma_evt)
);

// File: tb/tb_period_timer.sv
`timescale 1ns/1ps
module tb_period_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        man_stb = 1'b0;
  logic        auto_stb = 1'b0;
  logic        cnt_stb;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tmr_out, irq, dma_evt;

  int checks = 0, failures = 0;
  int auto_div = 0, auto_ph = 0;
  int irq_n = 0, mism_n = 0;
  string phase = "R1";

  always #4 clk = ~clk;
  assign cnt_stb = man_stb | auto_stb;

  period_timer dut (
    .clk(clk), .rst_n(rst_n), .cnt_stb(cnt_stb), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tmr_out(tmr_out), .irq(irq), .dma_evt(dma_evt)
  );

  // behavioural reference state
  logic [31:0] m_cnt, m_prd;
  bit m_run, m_sq, m_wide, m_pint, m_pinv, m_plvl, m_stat, m_prev;
  int m_left;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_prd = 0; m_run = 0; m_sq = 0; m_wide = 0;
      m_pint = 0; m_pinv = 0; m_plvl = 0; m_stat = 0; m_prev = 0; m_left = 0;
    end else begin
      automatic bit hit = m_run && (m_cnt == m_prd);
      automatic logic [31:0] nxt = m_cnt + 32'd1;
      automatic bit soon = m_run && cnt_stb && (nxt == m_prd);
      automatic bit old_stat = m_stat;
      if (hit) begin
        m_stat = m_sq ? !m_stat : 1'b1;
        m_left = m_wide ? 2 : 1;
      end else if (!m_sq && m_run && cnt_stb && m_left > 0) begin
        m_left = m_left - 1;
        if (m_left == 0 && !soon) m_stat = 0;
      end
      m_prev = old_stat;
      if (reg_we && reg_addr == 2'd2) m_cnt = reg_wdata;
      else if (reg_we && reg_addr == 2'd0 && reg_wdata[0] && reg_wdata[1]) m_cnt = 0;
      else if (hit) m_cnt = 0;
      else if (m_run && cnt_stb) m_cnt = nxt;
      if (reg_we && reg_addr == 2'd1) m_prd = reg_wdata;
      if (reg_we && reg_addr == 2'd0) begin
        m_run = reg_wdata[0]; m_sq = reg_wdata[2]; m_wide = reg_wdata[3];
        m_pint = reg_wdata[4]; m_pinv = reg_wdata[5]; m_plvl = reg_wdata[6];
      end
    end
  end

  function automatic logic [31:0] model_read(logic [1:0] a);
    case (a)
      2'd0: model_read = {20'd0, m_stat, 4'd0, m_plvl, m_pinv, m_pint, m_wide, m_sq, 1'b0, m_run};
      2'd1: model_read = m_prd;
      2'd2: model_read = m_cnt;
      default: model_read = 0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      automatic bit exp_irq = m_stat && !m_prev;
      automatic bit exp_pin = m_pint ? (m_stat ^ m_pinv) : m_plvl;
      check({phase, " pin (R10)"}, {31'd0, tmr_out}, {31'd0, exp_pin});
      check({phase, " irq (R9)"}, {31'd0, irq}, {31'd0, exp_irq});
      check({phase, " dma (R9)"}, {31'd0, dma_evt}, {31'd0, exp_irq});
      check({phase, " rdata"}, reg_rdata, model_read(reg_addr));
      if (irq) irq_n++;
      if (irq !== dma_evt) mism_n++;
    end
  end

  always @(negedge clk) begin
    if (auto_div > 0) begin
      auto_ph = (auto_ph + 1) % auto_div;
      auto_stb <= (auto_ph == 0);
    end else begin
      auto_stb <= 1'b0;
    end
  end

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic strobe();
    @(negedge clk); man_stb = 1;
    @(negedge clk); man_stb = 0;
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic a, b;
    int snap, lows;
    repeat (3) @(negedge clk);
    rst_n = 1;

    phase = "R1";
    rd(2'd0, v); check("R1 ctl after reset", v, 32'h0);
    rd(2'd1, v); check("R1 prd after reset", v, 32'h0);
    rd(2'd2, v); check("R1 cnt after reset", v, 32'h0);
    rd(2'd3, v); check("R1 unused address", v, 32'h0);
    check("R1 pin after reset", {31'd0, tmr_out}, 32'h0);
    check("R1 irq after reset", {31'd0, irq}, 32'h0);

    phase = "R2";
    wr(2'd1, 32'd3);
    wr(2'd0, 32'h13);
    rd(2'd2, v); check("R2 start zeroes count", v, 32'd0);
    rd(2'd0, v); check("R2 start bit reads 0", v, 32'h11);

    phase = "R3";
    strobe(); rd(2'd2, v); check("R3 count after 1 strobe", v, 32'd1);
    strobe(); rd(2'd2, v); check("R3 count after 2 strobes", v, 32'd2);
    strobe(); rd(2'd2, v); check("R3 wrap at period", v, 32'd0);
    phase = "R6";
    check("R6 pulse high after match", {31'd0, tmr_out}, 32'd1);
    strobe(); check("R6 pulse low after one strobe", {31'd0, tmr_out}, 32'd0);

    phase = "R4";
    wr(2'd0, 32'h10);
    strobe(); strobe();
    rd(2'd2, v); check("R4 count frozen while held", v, 32'd1);
    wr(2'd0, 32'h11);
    strobe(); rd(2'd2, v); check("R4 resume without reset", v, 32'd2);

    phase = "R2";
    wr(2'd0, 32'h12);
    rd(2'd2, v); check("R2 start without run ignored", v, 32'd2);
    wr(2'd0, 32'h11);

    phase = "R8";
    @(negedge clk); man_stb = 1; reg_we = 1; reg_addr = 2'd2; reg_wdata = 32'd100;
    @(negedge clk); man_stb = 0; reg_we = 0;
    rd(2'd2, v); check("R8 write beats increment", v, 32'd100);
    @(negedge clk); reg_we = 1; reg_addr = 2'd2; reg_wdata = 32'd3;
    @(negedge clk); reg_wdata = 32'd7;
    @(negedge clk); reg_we = 0;
    rd(2'd2, v); check("R8 write beats wrap", v, 32'd7);

    phase = "R5";
    wr(2'd2, 32'hFFFF_FFFE);
    strobe(); rd(2'd2, v); check("R5 count to all ones", v, 32'hFFFF_FFFF);
    strobe(); rd(2'd2, v); check("R5 rollover to 0", v, 32'd0);

    phase = "R6";
    wr(2'd1, 32'd2);
    wr(2'd0, 32'h1B);
    auto_div = 3;
    repeat (15) @(negedge clk);
    lows = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); if (tmr_out == 1'b0) lows++;
    end
    check("R6 stays high when period <= width", lows, 0);
    wr(2'd1, 32'd5);
    repeat (80) @(negedge clk);
    auto_div = 0;
    repeat (4) @(negedge clk);

    phase = "R7";
    wr(2'd1, 32'd0);
    wr(2'd0, 32'h17);
    @(negedge clk); a = tmr_out;
    @(negedge clk); b = tmr_out;
    check("R7 period 0 toggles each clock", {31'd0, b}, {31'd0, ~a});
    snap = irq_n;
    repeat (20) @(negedge clk);
    check("R9 irq every other clock at period 0", irq_n - snap, 10);
    wr(2'd0, 32'h14);
    @(negedge clk); a = tmr_out;
    @(negedge clk); b = tmr_out;
    check("R7 held keeps value", {31'd0, b}, {31'd0, a});

    phase = "R6";
    wr(2'd0, 32'h13);
    repeat (3) @(negedge clk);
    check("R6 period 0 running high", {31'd0, tmr_out}, 32'd1);
    wr(2'd0, 32'h10);
    repeat (3) @(negedge clk);
    check("R6 period 0 held high", {31'd0, tmr_out}, 32'd1);

    phase = "R10";
    wr(2'd0, 32'h30); @(negedge clk);
    check("R10 inverted status", {31'd0, tmr_out}, 32'd0);
    wr(2'd0, 32'h40); @(negedge clk);
    check("R10 data bit 1", {31'd0, tmr_out}, 32'd1);
    wr(2'd0, 32'h00); @(negedge clk);
    check("R10 data bit 0", {31'd0, tmr_out}, 32'd0);

    phase = "R7";
    wr(2'd1, 32'd3);
    wr(2'd0, 32'h17);
    auto_div = 2;
    repeat (100) @(negedge clk);
    auto_div = 0;
    check("R9 irq equals dma", mism_n, 0);

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule